// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by combining two direction predictors and a chooser. The first, per-branch predictor keeps a short outcome history for each branch slot, selected by low PC bits. That history indexes a table of 2-bit saturating counters. The second, path-based predictor indexes its own counter table with a register holding the outcomes of the most recent retired branches. A third table of 2-bit counters, indexed by that same path history, decides which of the two answers is used.

A fetch unit presents a PC on the lookup stream. One cycle later the block returns the final direction together with both component directions. The pipeline carries the two component directions alongside the branch. When the branch resolves, it sends them back on the update stream with the PC and the real outcome. That update trains the per-branch counter, the path counter, the chooser, the per-branch history entry and the path history. The path history advances only on updates, so it follows retired outcomes.

The lookup stream has back-pressure. A response is held unchanged until it is taken with `rsp_ready`. While a response is waiting and `rsp_ready` is low, the block refuses new lookups. The update stream never stalls.

Top module: `tourney_predictor`

## Requirements
- R1: `req_ready` is high exactly when no response is pending or the pending one is being taken this cycle (`!rsp_valid || rsp_ready`). A lookup is accepted on a clock edge where `req_valid && req_ready`.
- R2: An accepted lookup raises `rsp_valid` on the next edge. While `rsp_valid && !rsp_ready`, `rsp_valid` and all prediction bits stay unchanged. After a handshake with no new acceptance, `rsp_valid` falls.
- R3: `rsp_local` is the MSB of the per-branch counter selected by the 10-bit history entry at slot `req_pc[11:2]`.
- R4: `rsp_global` is the MSB of the path counter selected by the 12-bit path history register.
- R5: `rsp_taken` equals `rsp_global` when the MSB of the chooser counter selected by the path history is 1, and equals `rsp_local` when that MSB is 0.
- R6: Every 2-bit counter that is trained steps up on a taken outcome and down on a not-taken outcome. It saturates at 3 and 0, and its MSB is its direction.
- R7: On an update, the chooser counter steps up (toward the path predictor) when only `upd_global` matched the outcome. It steps down when only `upd_local` matched. It is left as is when both matched or neither did.
- R8: Each update shifts the outcome into bit 0 of the per-branch history entry at slot `upd_pc[11:2]` and into bit 0 of the path history. The oldest bit is dropped in both.
- R9: After reset all counters hold 1 (weakly not-taken, chooser weakly per-branch), all histories are zero, and `rsp_valid` is low.
- R10: A lookup accepted in the same cycle as an update sees the tables as they were before that update. `upd_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_pc | input | 32 | PC of the branch to predict |
| rsp_valid | output | 1 | Prediction response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taken | output | 1 | Final predicted direction |
| rsp_local | output | 1 | Per-branch component direction |
| rsp_global | output | 1 | Path component direction |
| upd_valid | input | 1 | Resolved branch update valid |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_local | input | 1 | Saved per-branch component direction |
| upd_global | input | 1 | Saved path component direction |

## Verification
Predictions are due on the clock edge after acceptance. The bench samples `rsp_*` 5 ns after each rising edge and compares them with the reference model's result for the lookup accepted at that edge. `req_ready` is combinational, so it is checked 1 ns after the inputs are driven, before the edge it governs. The effect of an update shows up in the first lookup accepted on a later edge. The model therefore applies an update only after computing any lookup in the same cycle, which matches the read-before-write ordering. Training rules are checked indirectly: scripted pass sequences drive a counter or the chooser across its saturation and selection points, and the returned predictions are compared.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr2_t;
  localparam ctr2_t CTR_WEAK_LO = 2'b01;

  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
    ctr2_t nxt;
    if (up) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else    nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter ctr2_t INIT = CTR_WEAK_LO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             trn_en,
  input  logic [IDX_W-1:0] trn_idx,
  input  logic             trn_up
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [2*ENTRIES-1:0] cells;
  ctr2_t trn_cur;

  assign rd_ctr  = cells[{rd_idx, 1'b0} +: 2];
  assign trn_cur = cells[{trn_idx, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells <= {ENTRIES{INIT}};
    end else if (trn_en) begin
      cells[{trn_idx, 1'b0} +: 2] <= ctr_step(trn_cur, trn_up);
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W = 10,
  parameter int HW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] look_idx,
  output logic [HW-1:0]    look_hist,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [HW-1:0]    upd_hist,
  input  logic             upd_en,
  input  logic             upd_bit
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES*HW-1:0] rows;

  assign look_hist = rows[look_idx*HW +: HW];
  assign upd_hist  = rows[upd_idx*HW +: HW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rows <= '0;
    end else if (upd_en) begin
      rows[upd_idx*HW +: HW] <= {upd_hist[HW-2:0], upd_bit};
    end
  end
endmodule

// File: rtl/tp_path_hist.sv
module tp_path_hist #(
  parameter int GW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_bit,
  output logic [GW-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[GW-2:0], shift_bit};
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int SLOT_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_taken,
  output logic            rsp_local,
  output logic            rsp_global,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_local,
  input  logic            upd_global
);
  localparam int PC_LSB = 2;

  logic [SLOT_W-1:0]  look_slot, upd_slot;
  logic [LHIST_W-1:0] look_lhist, upd_lhist;
  logic [GHIST_W-1:0] ghr_q;
  ctr2_t              lctr, gctr, cctr;
  logic               accept;
  logic               cho_en, cho_up;

  assign look_slot = req_pc[PC_LSB +: SLOT_W];
  assign upd_slot  = upd_pc[PC_LSB +: SLOT_W];

  tp_hist_table #(.IDX_W(SLOT_W), .HW(LHIST_W)) u_lhist (
    .clk(clk), .rst_n(rst_n),
    .look_idx(look_slot), .look_hist(look_lhist),
    .upd_idx(upd_slot), .upd_hist(upd_lhist),
    .upd_en(upd_valid), .upd_bit(upd_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_LO)) u_lpat (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_lhist), .rd_ctr(lctr),
    .trn_en(upd_valid), .trn_idx(upd_lhist), .trn_up(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_LO)) u_gpat (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q), .rd_ctr(gctr),
    .trn_en(upd_valid), .trn_idx(ghr_q), .trn_up(upd_taken)
  );

  assign cho_en = upd_valid && (upd_local != upd_global);
  assign cho_up = (upd_global == upd_taken);

  tp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_LO)) u_chooser (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghr_q), .rd_ctr(cctr),
    .trn_en(cho_en), .trn_idx(ghr_q), .trn_up(cho_up)
  );

  tp_path_hist #(.GW(GHIST_W)) u_ghr (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_bit(upd_taken), .hist(ghr_q)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign upd_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_local  <= 1'b0;
      rsp_global <= 1'b0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_local  <= lctr[1];
      rsp_global <= gctr[1];
      rsp_taken  <= cctr[1] ? gctr[1] : lctr[1];
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_taken,
  input logic          rsp_local,
  input logic          rsp_global,
  input logic          upd_valid,
  input logic          upd_taken,
  input logic [GW-1:0] ghr
);
  // R1: a stalled response blocks new lookups
  p_stall_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R2: acceptance yields a response next cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2: stalled response is held
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_taken)
      && $stable(rsp_local) && $stable(rsp_global)));

  // R5: final direction is one of the two components
  p_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_taken == rsp_local || rsp_taken == rsp_global));

  // R8: path history takes in the outcome at bit 0
  p_ghr_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghr[0] == $past(upd_taken)
      && ghr[GW-1:1] == $past(ghr[GW-2:0])));

  // R8: path history holds without an update
  p_ghr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr));
endmodule

bind tourney_predictor tp_checker #(.GW(GHIST_W)) u_tp_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_taken(rsp_taken),
  .rsp_local(rsp_local), .rsp_global(rsp_global), .upd_valid(upd_valid),
  .upd_taken(upd_taken), .ghr(ghr_q)
);

// File: tb/tourney_predictor_test.sv
module tourney_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0, upd_valid = 1'b0;
  logic [31:0] req_pc = '0, upd_pc = '0;
  logic        upd_taken = 1'b0, upd_local = 1'b0, upd_global = 1'b0;
  logic        req_ready, rsp_valid, rsp_taken, rsp_local, rsp_global, upd_ready;

  int checks = 0;
  int failures = 0;

  // reference model state
  int lht[1024];
  int lpt[1024];
  int gpt[4096];
  int cho[4096];
  int ghr;
  bit ex_v, ex_t, ex_l, ex_g;

  always #10 clk = ~clk;

  tourney_predictor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pc(req_pc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_taken(rsp_taken), .rsp_local(rsp_local), .rsp_global(rsp_global),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_local(upd_local), .upd_global(upd_global)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic void model_look(input logic [31:0] pc, output bit l, output bit g, output bit t);
    int h;
    h = lht[(pc >> 2) & 1023];
    l = lpt[h] >= 2;
    g = gpt[ghr] >= 2;
    t = (cho[ghr] >= 2) ? g : l;
  endfunction

  function automatic void model_upd(input logic [31:0] pc, input bit t, input bit l, input bit g);
    int s, h;
    s = (pc >> 2) & 1023;
    h = lht[s];
    lpt[h] = sat(lpt[h], t);
    gpt[ghr] = sat(gpt[ghr], t);
    if (l != g) cho[ghr] = sat(cho[ghr], g == t);
    lht[s] = ((h << 1) | t) & 1023;
    ghr = ((ghr << 1) | t) & 4095;
  endfunction

  function automatic void model_reset();
    foreach (lht[i]) lht[i] = 0;
    foreach (lpt[i]) lpt[i] = 1;
    foreach (gpt[i]) gpt[i] = 1;
    foreach (cho[i]) cho[i] = 1;
    ghr = 0;
    ex_v = 0; ex_t = 0; ex_l = 0; ex_g = 0;
  endfunction

  // One clock: drive, check ready, advance model, sample after edge.
  // auto=1 fills the saved component predictions from the model.
  task automatic step(input string tag, input bit lv, input logic [31:0] lpc, input bit rr,
                      input bit uv, input logic [31:0] upc, input bit ut,
                      input bit auto, input bit ul, input bit ug);
    bit l, g, t, accept;
    if (auto && uv) begin
      model_look(upc, l, g, t);
      ul = l; ug = g;
    end
    req_valid = lv; req_pc = lpc; rsp_ready = rr;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_local = ul; upd_global = ug;
    #1;
    chk({"R1 req_ready ", tag}, req_ready, !ex_v || rr);
    chk({"R10 upd_ready ", tag}, upd_ready, 1'b1);
    accept = lv && (!ex_v || rr);
    if (accept) begin
      model_look(lpc, l, g, t);   // R10: lookup sees pre-update state
      ex_v = 1; ex_l = l; ex_g = g; ex_t = t;
    end else if (rr) ex_v = 0;
    if (uv) model_upd(upc, ut, ul, ug);
    @(posedge clk); #5;
    chk({"R2 rsp_valid ", tag}, rsp_valid, ex_v);
    if (ex_v) begin
      chk({"R3 rsp_local ", tag}, rsp_local, ex_l);
      chk({"R4 rsp_global ", tag}, rsp_global, ex_g);
      chk({"R5 rsp_taken ", tag}, rsp_taken, ex_t);
    end
  endtask

  // lookup then train one branch with outcome t
  task automatic run_branch(input string tag, input logic [31:0] pc, input bit t);
    step(tag, 1, pc, 1, 0, 0, 0, 1, 0, 0);
    step(tag, 0, 0, 1, 1, pc, t, 1, 0, 0);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(posedge clk);
    #5;
    chk("R9 rsp_valid after reset", rsp_valid, 1'b0);
    rst_n = 1'b1;

    // R9: fresh lookup is not-taken; one taken update flips weak counters
    step("R9", 1, 32'h100, 1, 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 1, 1, 32'h100, 1, 1, 0, 0);
    step("R9", 1, 32'h100, 1, 0, 0, 0, 1, 0, 0);

    // R6: saturate upward, then a single not-taken keeps direction
    for (int i = 0; i < 20; i++) run_branch("R6", 32'h0, 1);
    run_branch("R6", 32'h0, 0);
    run_branch("R6", 32'h0, 1);
    for (int i = 0; i < 20; i++) run_branch("R6", 32'h0, 0);

    // R7: forced saved predictions exercise all chooser cases
    step("R7", 0, 0, 1, 1, 32'h40, 1, 0, 0, 1);
    step("R7", 0, 0, 1, 1, 32'h40, 1, 0, 1, 1);
    step("R7", 0, 0, 1, 1, 32'h40, 0, 0, 1, 1);
    step("R7", 0, 0, 1, 1, 32'h40, 0, 0, 1, 0);
    step("R7", 1, 32'h40, 1, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step("R7", 0, 0, 1, 1, 32'h44, 1, 0, 1, 0);
      step("R7", 0, 0, 1, 1, 32'h44, 0, 0, 1, 0);
      step("R7", 1, 32'h44, 1, 0, 0, 0, 1, 0, 0);
    end

    // R8: loop pattern TTTN on one PC, alternating on another
    for (int i = 0; i < 40; i++) run_branch("R8", 32'h200, (i % 4) != 3);
    for (int i = 0; i < 30; i++) run_branch("R8", 32'h1204, i[0]);

    // R2: back-pressure holds the response, lookups refused
    step("R2", 1, 32'h200, 0, 0, 0, 0, 1, 0, 0);
    step("R2", 1, 32'h204, 0, 1, 32'h204, 1, 1, 0, 0);
    step("R2", 1, 32'h208, 0, 0, 0, 0, 1, 0, 0);
    step("R2", 1, 32'h208, 1, 0, 0, 0, 1, 0, 0);
    step("R2", 0, 0, 1, 0, 0, 0, 1, 0, 0);

    // R10: lookup and update of the same PC in one cycle
    step("R10", 1, 32'h300, 1, 1, 32'h300, 1, 1, 0, 0);
    step("R10", 1, 32'h300, 1, 1, 32'h300, 1, 1, 0, 0);
    step("R10", 1, 32'h300, 1, 0, 0, 0, 1, 0, 0);

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R3", lfsr[0], {18'd0, lfsr[7:2], 8'd0} ^ {22'd0, lfsr[15:8], 2'b00},
           lfsr[1] | lfsr[9], lfsr[3], {20'd0, lfsr[5:4], 10'd0} ^ {24'd0, lfsr[15:12], 4'd0},
           lfsr[11] ^ lfsr[6], 1, 0, 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule